// File: doc/BRIEF.md
# Dual-Mode Program Counter Unit

This unit holds the program counter of a processor core that can execute from two address spaces. The low part of the address range names 32-bit words in a small local memory, one word per address. Everything above it names bytes in a large shared memory. The unit works out which space the current address lies in and raises a select flag that tells the fetch path where to read. It advances the counter by the stride that space uses, and it computes the targets of sequential steps, short relative branches, long relative branches and absolute branches.

Relative offsets are rescaled by the current space, so one binary image runs unchanged from either memory. Long offsets are written in byte units and scaled down for local execution. Short offsets count instructions and are scaled up for shared execution. Shared-space code may sit at any byte address, so no alignment is ever forced on the counter. Local-space arithmetic wraps inside the local window, so only an absolute branch or shared-space arithmetic can move execution between the spaces.

Top module: `dual_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter is loaded with 0, so `fetch_addr_o` reads 0x00000 and `shared_sel_o` reads 0.
- R2: In local mode (counter below 0x400), a step with no accepted branch adds 1 to the counter.
- R3: In shared mode (counter at or above 0x400), a step with no accepted branch adds 4 to the counter. Alignment is kept as it is, so 0x401 steps to 0x405.
- R4: `shared_sel_o` is 1 exactly when `fetch_addr_o` is 0x400 or above. It follows every counter update, including branches that cross the boundary in either direction.
- R5: A short relative branch (`br_kind_i` = 2'b00) takes its offset from `br_operand_i[8:0]` as a two's-complement instruction count. The target is (counter + stride) + offset in local mode, and (counter + stride) + 4·offset in shared mode.
- R6: A long relative branch (`br_kind_i` = 2'b01) takes the 20-bit two's-complement byte offset in `br_operand_i`. The target is (counter + stride) + offset in shared mode, and (counter + stride) + (offset arithmetically shifted right by 2) in local mode. Shared-mode sums wrap modulo 2^20.
- R7: An absolute branch (`br_kind_i` = 2'b10) loads `br_operand_i` unchanged, at any byte alignment and in either space.
- R8: In local mode, a step or relative branch whose result falls outside 0x000..0x3FF keeps only the low 10 bits, so execution stays in local space.
- R9: An accepted branch takes priority over a step. With `br_valid_i` low, or with the reserved kind 2'b11, the counter only steps if `step_i` is high and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance to the next sequential instruction |
| br_valid_i | input | 1 | A branch request is present this cycle |
| br_kind_i | input | 2 | 00 short relative, 01 long relative, 10 absolute, 11 reserved (no branch) |
| br_operand_i | input | 20 | Relative offset or absolute target |
| fetch_addr_o | output | 20 | Current program counter, used as the fetch address |
| shared_sel_o | output | 1 | 1 when the fetch address lies in shared space |

## Verification
Step and branch requests presented in one cycle appear on `fetch_addr_o` right after the next rising edge, because the counter is the only register in the path. `shared_sel_o` is decoded from that counter in the same cycle. The bench drives each request on a falling edge and compares both outputs on the following falling edge against a bench-side model. That timing is exactly one register stage, with no sample taken near an active edge. Directed cases cover boundary crossings, local wrap and unaligned shared addresses, and seeded random requests aimed around 0x400 fill in the mix.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int unsigned DEF_PC_W        = 20;
    localparam int unsigned DEF_LOCAL_DEPTH = 1024;
    localparam int unsigned DEF_SHORT_W     = 9;
    localparam int unsigned DEF_BYTE_SHIFT  = 2;

    typedef enum logic [1:0] {
        BR_SHORT = 2'b00,
        BR_LONG  = 2'b01,
        BR_ABS   = 2'b10,
        BR_RSVD  = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        SEL_HOLD   = 2'b00,
        SEL_SEQ    = 2'b01,
        SEL_REL    = 2'b10,
        SEL_ABS    = 2'b11
    } next_sel_e;

    typedef struct packed {
        next_sel_e sel;
        logic      long_rel;
    } pc_ctrl_t;

endpackage

// File: rtl/pc_space_decode.sv
module pc_space_decode #(
    parameter int unsigned PC_W        = pc_pkg::DEF_PC_W,
    parameter int unsigned LOCAL_DEPTH = pc_pkg::DEF_LOCAL_DEPTH
) (
    input  logic [PC_W-1:0] addr_i,
    output logic            is_shared_o
);
    localparam logic [PC_W-1:0] LIMIT = PC_W'(LOCAL_DEPTH);

    always_comb begin
        is_shared_o = (addr_i >= LIMIT);
    end
endmodule

// File: rtl/pc_branch_ctrl.sv
module pc_branch_ctrl
    import pc_pkg::*;
(
    input  logic     step_i,
    input  logic     br_valid_i,
    input  br_kind_e br_kind_i,
    output pc_ctrl_t ctrl_o
);
    always_comb begin
        ctrl_o.sel      = SEL_HOLD;
        ctrl_o.long_rel = 1'b0;
        if (br_valid_i && br_kind_i != BR_RSVD) begin
            unique case (br_kind_i)
                BR_ABS:   ctrl_o.sel = SEL_ABS;
                BR_LONG:  begin
                    ctrl_o.sel      = SEL_REL;
                    ctrl_o.long_rel = 1'b1;
                end
                default:  ctrl_o.sel = SEL_REL;
            endcase
        end else if (step_i) begin
            ctrl_o.sel = SEL_SEQ;
        end
    end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
    import pc_pkg::*;
#(
    parameter int unsigned PC_W        = DEF_PC_W,
    parameter int unsigned LOCAL_DEPTH = DEF_LOCAL_DEPTH,
    parameter int unsigned SHORT_W     = DEF_SHORT_W,
    parameter int unsigned BYTE_SHIFT  = DEF_BYTE_SHIFT
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            is_shared_i,
    input  pc_ctrl_t        ctrl_i,
    input  logic [PC_W-1:0] operand_i,
    output logic [PC_W-1:0] next_o
);
    localparam int unsigned LOCAL_AW = $clog2(LOCAL_DEPTH);
    localparam logic [PC_W-1:0] SHARED_STRIDE = PC_W'(1) << BYTE_SHIFT;

    logic [PC_W-1:0] base;
    logic [PC_W-1:0] short_ext;
    logic [PC_W-1:0] short_off;
    logic [PC_W-1:0] long_off;
    logic [PC_W-1:0] rel_off;
    logic [PC_W-1:0] raw;
    logic [PC_W-1:0] local_fit;

    // Sign-extend the short offset to counter width.
    generate
        if (SHORT_W < PC_W) begin : g_short_ext
            assign short_ext = {{(PC_W-SHORT_W){operand_i[SHORT_W-1]}},
                                operand_i[SHORT_W-1:0]};
        end else begin : g_short_full
            assign short_ext = operand_i;
        end
    endgenerate

    // Space-dependent scaling of the two relative encodings.
    generate
        if (BYTE_SHIFT == 0) begin : g_no_scale
            assign short_off = short_ext;
            assign long_off  = operand_i;
        end else begin : g_scale
            assign short_off = is_shared_i ? (short_ext << BYTE_SHIFT) : short_ext;
            assign long_off  = is_shared_i ? operand_i
                                           : PC_W'($signed(operand_i) >>> BYTE_SHIFT);
        end
    endgenerate

    // Keep local-space results inside the local window.
    generate
        if (LOCAL_AW < PC_W) begin : g_wrap
            assign local_fit = {{(PC_W-LOCAL_AW){1'b0}}, raw[LOCAL_AW-1:0]};
        end else begin : g_nowrap
            assign local_fit = raw;
        end
    endgenerate

    always_comb begin
        base    = pc_i + (is_shared_i ? SHARED_STRIDE : PC_W'(1));
        rel_off = ctrl_i.long_rel ? long_off : short_off;
        unique case (ctrl_i.sel)
            SEL_SEQ: raw = base;
            SEL_REL: raw = base + rel_off;
            SEL_ABS: raw = operand_i;
            default: raw = pc_i;
        endcase
        if (ctrl_i.sel == SEL_ABS || ctrl_i.sel == SEL_HOLD || is_shared_i) begin
            next_o = raw;
        end else begin
            next_o = local_fit;
        end
    end
endmodule

// File: rtl/dual_pc_unit.sv
module dual_pc_unit
    import pc_pkg::*;
#(
    parameter int unsigned PC_W        = DEF_PC_W,
    parameter int unsigned LOCAL_DEPTH = DEF_LOCAL_DEPTH,
    parameter int unsigned SHORT_W     = DEF_SHORT_W,
    parameter int unsigned BYTE_SHIFT  = DEF_BYTE_SHIFT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_i,
    input  logic            br_valid_i,
    input  logic [1:0]      br_kind_i,
    input  logic [PC_W-1:0] br_operand_i,
    output logic [PC_W-1:0] fetch_addr_o,
    output logic            shared_sel_o
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_next;
    logic            in_shared;
    pc_ctrl_t        ctrl;

    pc_space_decode #(
        .PC_W        (PC_W),
        .LOCAL_DEPTH (LOCAL_DEPTH)
    ) u_space (
        .addr_i      (pc_q),
        .is_shared_o (in_shared)
    );

    pc_branch_ctrl u_ctrl (
        .step_i     (step_i),
        .br_valid_i (br_valid_i),
        .br_kind_i  (br_kind_e'(br_kind_i)),
        .ctrl_o     (ctrl)
    );

    pc_next_calc #(
        .PC_W        (PC_W),
        .LOCAL_DEPTH (LOCAL_DEPTH),
        .SHORT_W     (SHORT_W),
        .BYTE_SHIFT  (BYTE_SHIFT)
    ) u_calc (
        .pc_i        (pc_q),
        .is_shared_i (in_shared),
        .ctrl_i      (ctrl),
        .operand_i   (br_operand_i),
        .next_o      (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign fetch_addr_o = pc_q;
    assign shared_sel_o = in_shared;
endmodule

// File: rtl/dual_pc_checker.sv
module dual_pc_checker #(
    parameter int unsigned PC_W        = 20,
    parameter int unsigned LOCAL_DEPTH = 1024,
    parameter int unsigned BYTE_SHIFT  = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            step_i,
    input logic            br_valid_i,
    input logic [1:0]      br_kind_i,
    input logic [PC_W-1:0] br_operand_i,
    input logic [PC_W-1:0] fetch_addr_o,
    input logic            shared_sel_o
);
    localparam logic [PC_W-1:0] LIMIT = PC_W'(LOCAL_DEPTH);
    localparam logic [PC_W-1:0] MASK  = PC_W'(LOCAL_DEPTH - 1);
    localparam logic [PC_W-1:0] WIDE  = PC_W'(1) << BYTE_SHIFT;

    logic no_branch;
    assign no_branch = !br_valid_i || (br_kind_i == 2'b11);

    AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
        shared_sel_o == (fetch_addr_o >= LIMIT)); // R4

    AST_LOCAL_STEP: assert property (@(posedge clk) disable iff (rst)
        (!shared_sel_o && step_i && no_branch)
        |=> fetch_addr_o == (($past(fetch_addr_o) + PC_W'(1)) & MASK)); // R2

    AST_SHARED_STEP: assert property (@(posedge clk) disable iff (rst)
        (shared_sel_o && step_i && no_branch)
        |=> fetch_addr_o == $past(fetch_addr_o) + WIDE); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!step_i && no_branch) |=> $stable(fetch_addr_o)); // R9

    AST_ABS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (br_valid_i && br_kind_i == 2'b10)
        |=> fetch_addr_o == $past(br_operand_i)); // R7

    AST_LOCAL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!shared_sel_o && !(br_valid_i && br_kind_i == 2'b10))
        |=> !shared_sel_o); // R8
endmodule

bind dual_pc_unit dual_pc_checker #(
    .PC_W        (PC_W),
    .LOCAL_DEPTH (LOCAL_DEPTH),
    .BYTE_SHIFT  (BYTE_SHIFT)
) u_dual_pc_checker (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step_i),
    .br_valid_i   (br_valid_i),
    .br_kind_i    (br_kind_i),
    .br_operand_i (br_operand_i),
    .fetch_addr_o (fetch_addr_o),
    .shared_sel_o (shared_sel_o)
);

// File: tb/dual_pc_unit_bench.sv
`timescale 1ns/1ps
module dual_pc_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        step_i;
    logic        br_valid_i;
    logic [1:0]  br_kind_i;
    logic [19:0] br_operand_i;
    logic [19:0] fetch_addr_o;
    logic        shared_sel_o;

    int checks = 0;
    int fails  = 0;
    logic [19:0] exp_pc;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dual_pc_unit u_dual_pc_unit (
        .clk          (clk),
        .rst          (rst),
        .step_i       (step_i),
        .br_valid_i   (br_valid_i),
        .br_kind_i    (br_kind_i),
        .br_operand_i (br_operand_i),
        .fetch_addr_o (fetch_addr_o),
        .shared_sel_o (shared_sel_o)
    );

    // Unwrapped next counter value from the requirements.
    function automatic logic [19:0] raw_next(logic [19:0] pc, logic st, logic v,
                                             logic [1:0] k, logic [19:0] op);
        logic        sh;
        logic [19:0] base;
        logic [19:0] s9;
        sh   = (pc >= 20'h400);
        base = pc + (sh ? 20'd4 : 20'd1);
        s9   = {{11{op[8]}}, op[8:0]};
        if (v && k == 2'b10) return op;
        if (v && k == 2'b00) return base + (sh ? (s9 * 20'd4) : s9);
        if (v && k == 2'b01) return base + (sh ? op : {{2{op[19]}}, op[19:2]});
        if (st) return base;
        return pc;
    endfunction

    function automatic logic [19:0] model(logic [19:0] pc, logic st, logic v,
                                          logic [1:0] k, logic [19:0] op);
        logic [19:0] r;
        r = raw_next(pc, st, v, k, op);
        if (pc < 20'h400 && !(v && k == 2'b10)) r = r & 20'h003FF;
        return r;
    endfunction

    function automatic string classify(logic [19:0] pc, logic st, logic v,
                                       logic [1:0] k, logic [19:0] op);
        if (v && k == 2'b10) return "R7";
        if (model(pc, st, v, k, op) != raw_next(pc, st, v, k, op)) return "R8";
        if (v && k == 2'b00) return "R5";
        if (v && k == 2'b01) return "R6";
        if (st) return (pc >= 20'h400) ? "R3" : "R2";
        return "R9";
    endfunction

    task automatic check_outputs(string tag);
        checks++;
        if (fetch_addr_o !== exp_pc) begin
            fails++;
            $display("FAIL %s fetch_addr actual=%05h expected=%05h", tag, fetch_addr_o, exp_pc);
        end
        checks++;
        if (shared_sel_o !== (exp_pc >= 20'h400)) begin
            fails++;
            $display("FAIL R4 shared_sel actual=%0b expected=%0b (after %s)",
                     shared_sel_o, exp_pc >= 20'h400, tag);
        end
    endtask

    // Drive at a falling edge; compare at the next falling edge.
    task automatic apply(logic st, logic v, logic [1:0] k, logic [19:0] op, string tag);
        string t;
        t = (tag == "") ? classify(exp_pc, st, v, k, op) : tag;
        step_i = st; br_valid_i = v; br_kind_i = k; br_operand_i = op;
        exp_pc = model(exp_pc, st, v, k, op);
        @(negedge clk);
        check_outputs(t);
    endtask

    initial begin
        void'($urandom(32'h0005EED1));
        rst = 1'b1; step_i = 1'b0; br_valid_i = 1'b0; br_kind_i = 2'b11; br_operand_i = '0;
        exp_pc = '0;
        repeat (3) @(negedge clk);
        check_outputs("R1");
        rst = 1'b0;

        apply(1, 0, 2'b00, 20'h0, "R2");           // 0 -> 1
        apply(0, 1, 2'b00, 20'h001FE, "R5");       // local short -2 -> 0
        apply(0, 1, 2'b10, 20'h003FF, "R7");
        apply(1, 0, 2'b00, 20'h0, "R8");           // 0x3FF wraps to 0
        apply(0, 1, 2'b10, 20'h00401, "R7");       // unaligned shared
        apply(1, 0, 2'b00, 20'h0, "R3");           // 0x405
        apply(0, 1, 2'b00, 20'h00003, "R5");       // 0x409 + 12 = 0x415
        apply(1, 1, 2'b01, 20'h00003, "R6");       // 0x419 + 3 = 0x41C
        apply(0, 1, 2'b01, 20'hFFFD0, "R6");       // 0x420 - 0x30 = 0x3F0
        apply(0, 1, 2'b01, 20'h00010, "R6");       // 0x3F1 + 4 = 0x3F5
        apply(0, 1, 2'b01, 20'hFFFF0, "R6");       // 0x3F6 - 4 = 0x3F2
        apply(0, 1, 2'b00, 20'h00020, "R8");       // 0x413 wraps to 0x013
        apply(1, 1, 2'b10, 20'h00500, "R9");       // branch beats step
        apply(0, 0, 2'b10, 20'h00777, "R9");       // no request holds
        apply(0, 1, 2'b11, 20'h00777, "R9");       // reserved kind holds
        apply(1, 1, 2'b11, 20'h00777, "R9");       // reserved kind steps: 0x504
        apply(0, 1, 2'b10, 20'hFFFFE, "R7");
        apply(1, 0, 2'b00, 20'h0, "R3");           // wraps to 0x00002, local

        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  k;
            logic [19:0] op;
            int unsigned pick;
            pick = $urandom_range(0, 9);
            k    = 2'($urandom_range(0, 3));
            op   = 20'($urandom);
            if (k == 2'b10 && pick < 6) op = 20'h3F0 + 20'($urandom_range(0, 31));
            if (k == 2'b01 && pick < 5) op = 20'($signed(8'($urandom)));
            apply(1'($urandom), (pick < 4), k, op, "");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule